// File: doc/BRIEF.md
# Sampling Delay Tap Calibrator

This block tunes a programmable sampling delay that sits in front of the read path of an external memory. A start pulse begins the run. The block first writes a known byte pattern into memory once. It then tests candidate delay taps one at a time. For each tap it reads the whole pattern back over a simple request/acknowledge port and compares every byte.

The search works from both ends of the tap range. It climbs from tap 0 to find the lowest passing tap. It then jumps to the top tap and descends to find the highest passing tap. It applies the truncated midpoint of those two taps and raises done. If either sweep runs off the end of the range without a pass, it raises an error instead.

The tap value drives the delay line directly. After every tap change the block waits a programmable number of cycles for the delay line to settle before the first read at that tap.

Top module: `tapcal_top`

## Requirements
- R1: While reset is held, busy, done and cal_err are low, tap_out is 0 and mem_req is low.
- R2: A start pulse seen while idle raises busy on the next cycle and clears done and cal_err. busy stays high until either done or cal_err rises, and the two are never high together. A start pulse seen while busy has no effect.
- R3: Each run first writes PAT_LEN bytes, once, to addresses 0 up to PAT_LEN-1 in ascending order, before any read. The byte at address i is 0x41 + (i mod 26), an ASCII alphabet repeated.
- R4: Once mem_req is raised, mem_req, mem_we, mem_addr and mem_wdata stay unchanged until mem_ack is sampled high. Each acknowledged cycle completes exactly one access.
- R5: Each tap test reads addresses 0 up to PAT_LEN-1 in ascending order. A single byte that differs from the pattern marks that tap as failed.
- R6: The upward sweep starts at tap 0 and steps up by one after each failed tap. The first passing tap becomes the window minimum.
- R7: After the minimum is found, the tap becomes 2^TAP_W-1 (15 by default). The downward sweep then steps down by one after each failed tap, and the first passing tap becomes the window maximum.
- R8: A failure at the top tap during the upward sweep, or at tap 0 during the downward sweep, ends the run with cal_err high. No further memory request is issued.
- R9: On success, tap_out becomes floor((minimum + maximum) / 2) in the same cycle that done rises.
- R10: The first read at a new tap value is requested exactly settle_cycles+1 cycles after tap_out changes. tap_out does not change while a read is requested.
- R11: After done or cal_err, tap_out, done and cal_err hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a calibration run when idle |
| settle_cycles | input | SETTLE_W | Wait after each tap change, in cycles, minus one |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 8 | Read data |
| tap_out | output | TAP_W | Delay tap driven to the delay line |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Calibration succeeded; tap_out holds the result |
| cal_err | output | 1 | No usable window was found |

## Verification
The bench builds the block with TAP_W=4 and a 40-byte pattern in a 6-bit address space. This keeps a worst-case run of 32 tap tests short while still covering every tap from 0 to 15. Settle values of 0, 3 and 15 cover the smallest, a middle and the largest setting of the 4-bit settle input.

The memory model takes separate pass masks for the two sweeps. This lets the downward sweep run all the way to tap 0 and fail there. The model can also corrupt a single chosen byte, so a tap that fails on one byte alone is exercised. Windows at both edges of the range, a one-tap window, a full window and an empty window drive the midpoint and the error paths.

// File: rtl/tapcal_pkg.sv
package tapcal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_SETTLE,
    ST_READ,
    ST_EVAL
  } cal_state_e;

  typedef enum logic {
    DIR_UP,
    DIR_DOWN
  } sweep_dir_e;

endpackage

// File: rtl/tapcal_patgen.sv
module tapcal_patgen #(
  parameter int ADDR_W   = 8,
  parameter int PAT_KIND = 0
) (
  input  logic [ADDR_W-1:0] idx,
  output logic [7:0]        pat_byte
);

  generate
    if (PAT_KIND == 0) begin : g_alpha
      localparam int ALPHA_N = 26;
      logic [ADDR_W-1:0] pos;
      always_comb begin
        pos      = idx % ADDR_W'(ALPHA_N);
        pat_byte = 8'h41 + 8'(pos);
      end
    end else begin : g_xor
      always_comb begin
        pat_byte = 8'(idx) ^ 8'h5A;
      end
    end
  endgenerate

endmodule

// File: rtl/tapcal_search.sv
module tapcal_search
  import tapcal_pkg::*;
#(
  parameter int TAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             eval,
  input  logic             fail,
  output logic [TAP_W-1:0] tap,
  output logic             step_more,
  output logic             step_done,
  output logic             step_abort
);

  localparam logic [TAP_W-1:0] TAP_TOP = {TAP_W{1'b1}};

  logic [TAP_W-1:0] tap_q, tap_d;
  logic [TAP_W-1:0] lo_q, lo_d;
  sweep_dir_e       dir_q, dir_d;
  logic [TAP_W:0]   span_sum;
  logic             upd_en;

  assign span_sum = {1'b0, lo_q} + {1'b0, tap_q};
  assign upd_en   = clr | eval;

  always_comb begin
    tap_d      = tap_q;
    lo_d       = lo_q;
    dir_d      = dir_q;
    step_more  = 1'b0;
    step_done  = 1'b0;
    step_abort = 1'b0;
    if (clr) begin
      tap_d = '0;
      lo_d  = '0;
      dir_d = DIR_UP;
    end else if (eval) begin
      if (dir_q == DIR_UP) begin
        if (fail) begin
          if (tap_q == TAP_TOP) begin
            step_abort = 1'b1;
          end else begin
            tap_d     = tap_q + 1'b1;
            step_more = 1'b1;
          end
        end else begin
          lo_d      = tap_q;
          dir_d     = DIR_DOWN;
          tap_d     = TAP_TOP;
          step_more = 1'b1;
        end
      end else begin
        if (fail) begin
          if (tap_q == '0) begin
            step_abort = 1'b1;
          end else begin
            tap_d     = tap_q - 1'b1;
            step_more = 1'b1;
          end
        end else begin
          tap_d     = span_sum[TAP_W:1];
          step_done = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= '0;
      lo_q  <= '0;
      dir_q <= DIR_UP;
    end else if (upd_en) begin
      tap_q <= tap_d;
      lo_q  <= lo_d;
      dir_q <= dir_d;
    end
  end

  assign tap = tap_q;

endmodule

// File: rtl/tapcal_top.sv
module tapcal_top
  import tapcal_pkg::*;
#(
  parameter int TAP_W    = 4,
  parameter int ADDR_W   = 8,
  parameter int PAT_LEN  = 234,
  parameter int SETTLE_W = 4,
  parameter int PAT_KIND = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [7:0]          mem_wdata,
  input  logic                mem_ack,
  input  logic [7:0]          mem_rdata,
  output logic [TAP_W-1:0]    tap_out,
  output logic                busy,
  output logic                done,
  output logic                cal_err
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(PAT_LEN - 1);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  cal_state_e          state_q, state_d;
  logic [ADDR_W-1:0]   idx_q, idx_d;
  logic [SETTLE_W-1:0] cnt_q, cnt_d;
  logic                miss_q, miss_d;
  logic                done_q, done_d;
  logic                err_q, err_d;
  logic                ctl_en;

  logic [7:0] exp_byte;
  logic       mismatch;
  logic       last_idx;
  logic       srch_clr, srch_eval;
  logic       step_more, step_done, step_abort;
  logic [TAP_W-1:0] tap_cur;

  tapcal_patgen #(
    .ADDR_W   (ADDR_W),
    .PAT_KIND (PAT_KIND)
  ) u_pat (
    .idx      (idx_q),
    .pat_byte (exp_byte)
  );

  assign srch_clr  = (state_q == ST_IDLE) && start;
  assign srch_eval = (state_q == ST_EVAL);

  tapcal_search #(
    .TAP_W (TAP_W)
  ) u_search (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr        (srch_clr),
    .eval       (srch_eval),
    .fail       (miss_q),
    .tap        (tap_cur),
    .step_more  (step_more),
    .step_done  (step_done),
    .step_abort (step_abort)
  );

  assign mismatch = (mem_rdata != exp_byte);
  assign last_idx = (idx_q == LAST_IDX);
  assign ctl_en   = (state_q != ST_IDLE) || start;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    miss_d  = miss_q;
    done_d  = done_q;
    err_d   = err_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_WRITE;
          idx_d   = '0;
          done_d  = 1'b0;
          err_d   = 1'b0;
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          if (last_idx) begin
            state_d = ST_SETTLE;
            idx_d   = '0;
            cnt_d   = settle_cycles;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_SETTLE: begin
        if (cnt_q == '0) begin
          state_d = ST_READ;
          miss_d  = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_READ: begin
        if (mem_ack) begin
          miss_d = miss_q | mismatch;
          if (last_idx) begin
            state_d = ST_EVAL;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_EVAL: begin
        idx_d = '0;
        if (step_abort) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else if (step_done) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (step_more) begin
          state_d = ST_SETTLE;
          cnt_d   = settle_cycles;
        end else begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      miss_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (ctl_en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      miss_q  <= miss_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign mem_req   = (state_q == ST_WRITE) || (state_q == ST_READ);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = idx_q;
  assign mem_wdata = exp_byte;
  assign tap_out   = tap_cur;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign cal_err   = err_q;

endmodule

// File: rtl/tapcal_chk.sv
module tapcal_chk #(
  parameter int TAP_W  = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic [TAP_W-1:0]  tap_out,
  input logic              busy,
  input logic              done,
  input logic              cal_err
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R4

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && cal_err)); // R2

  AST_BUSY_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done && !cal_err); // R2

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && !done && !cal_err); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R8

  AST_TAP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> $stable(tap_out)); // R10

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done || cal_err) && !start |=> $stable(tap_out) && $stable(done) && $stable(cal_err)); // R11

endmodule

bind tapcal_top tapcal_chk #(
  .TAP_W  (TAP_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .tap_out   (tap_out),
  .busy      (busy),
  .done      (done),
  .cal_err   (cal_err)
);

// File: tb/sim_tapcal_top.sv
`timescale 1ns/1ps
module sim_tapcal_top;

  localparam int TAP_W    = 4;
  localparam int ADDR_W   = 6;
  localparam int PAT_LEN  = 40;
  localparam int SETTLE_W = 4;

  logic                clk;
  logic                rst_n;
  logic                start;
  logic [SETTLE_W-1:0] settle_cycles;
  logic                mem_req, mem_we, mem_ack;
  logic [ADDR_W-1:0]   mem_addr;
  logic [7:0]          mem_wdata, mem_rdata;
  logic [TAP_W-1:0]    tap_out;
  logic                busy, done, cal_err;

  tapcal_top #(
    .TAP_W    (TAP_W),
    .ADDR_W   (ADDR_W),
    .PAT_LEN  (PAT_LEN),
    .SETTLE_W (SETTLE_W),
    .PAT_KIND (0)
  ) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .settle_cycles (settle_cycles),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .tap_out       (tap_out),
    .busy          (busy),
    .done          (done),
    .cal_err       (cal_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat_of(input int i);
    return 8'(8'h41 + (i % 26));
  endfunction

  // memory model with tap-dependent corruption
  logic [7:0]  mem_arr [0:(1<<ADDR_W)-1];
  logic [15:0] mask_a, mask_b;
  int          corrupt_at;
  bit          sw, cur_bad, bad;

  initial begin
    mem_ack   = 1'b0;
    mem_rdata = 8'h00;
    forever begin
      @(posedge clk);
      if (mem_req && !mem_ack) begin
        if (mem_we) begin
          mem_arr[mem_addr] = mem_wdata;
        end else begin
          bad = !(sw ? mask_b[tap_out] : mask_a[tap_out]) &&
                (corrupt_at < 0 || int'(mem_addr) == corrupt_at);
          mem_rdata <= mem_arr[mem_addr] ^ (bad ? 8'h01 : 8'h00);
          if (mem_addr == '0) cur_bad = bad;
          else                cur_bad = cur_bad | bad;
          if (int'(mem_addr) == PAT_LEN - 1 && !cur_bad) sw = 1'b1;
        end
        mem_ack <= 1'b1;
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  // reference model: expected tap sequence, compared on every clock
  int exp_q[$];
  int cur_settle;
  bit mon_en;
  bit in_test, tap_changed, first_test, prev_pend, prev_we;
  logic [TAP_W-1:0]  prev_tap;
  logic [ADDR_W-1:0] prev_addr;
  logic [7:0]        prev_wdata;
  int gap, wr_cnt, wr_bad, rd_idx, rd_bad, hs_bad, exp_t;

  initial begin
    mon_en = 1'b0;
    forever begin
      @(negedge clk);
      if (mon_en) begin
        if (tap_out != prev_tap) begin
          gap = 0;
          tap_changed = 1'b1;
        end else begin
          gap++;
        end
        prev_tap = tap_out;
        if (prev_pend && !(mem_req && mem_addr == prev_addr && mem_we == prev_we &&
                           mem_wdata == prev_wdata)) hs_bad++;
        prev_pend  = mem_req && !mem_ack;
        prev_addr  = mem_addr;
        prev_we    = mem_we;
        prev_wdata = mem_wdata;
        if (mem_req && mem_we) tap_changed = 1'b0;
        if (mem_req && !mem_we && !in_test) begin
          in_test = 1'b1;
          if (first_test) begin
            chk(wr_cnt == PAT_LEN, "R3 writes done before first read", wr_cnt, PAT_LEN);
            first_test = 1'b0;
          end
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6 R7 unexpected extra tap test", int'(tap_out), -1);
          end else begin
            exp_t = exp_q.pop_front();
            chk(int'(tap_out) == exp_t, "R6 R7 tested tap", int'(tap_out), exp_t);
          end
          if (tap_changed) begin
            chk(gap == cur_settle + 1, "R10 settle gap", gap, cur_settle + 1);
            tap_changed = 1'b0;
          end
        end
        if (mem_req && mem_ack) begin
          if (mem_we) begin
            if (int'(mem_addr) != wr_cnt || mem_wdata != pat_of(wr_cnt) || !first_test) wr_bad++;
            wr_cnt++;
          end else begin
            if (int'(mem_addr) != rd_idx) rd_bad++;
            rd_idx++;
            if (int'(mem_addr) == PAT_LEN - 1) begin
              in_test = 1'b0;
              rd_idx  = 0;
            end
          end
        end
      end
    end
  end

  task automatic build_exp(input logic [15:0] ma, input logic [15:0] mb,
                           output int fin, output bit e);
    int t, lo;
    bit found;
    exp_q.delete();
    e = 1'b0; fin = 0; lo = 0; found = 1'b0;
    t = 0;
    while (!found && !e) begin
      exp_q.push_back(t);
      if (ma[t]) begin lo = t; found = 1'b1; end
      else if (t == 15) e = 1'b1;
      else t++;
    end
    if (!e) begin
      found = 1'b0;
      t = 15;
      while (!found && !e) begin
        exp_q.push_back(t);
        if (mb[t]) found = 1'b1;
        else if (t == 0) e = 1'b1;
        else t--;
      end
      fin = (lo + t) / 2;
    end
  endtask

  task automatic run_cal(input logic [15:0] ma, input logic [15:0] mb, input int corr,
                         input int settle, input bit extra_start);
    int fin, reqs;
    bit e;
    logic [TAP_W-1:0] held_tap;
    build_exp(ma, mb, fin, e);
    for (int i = 0; i < (1 << ADDR_W); i++) mem_arr[i] = 8'h00;
    mask_a = ma; mask_b = mb; corrupt_at = corr; sw = 1'b0; cur_bad = 1'b0;
    settle_cycles = SETTLE_W'(settle);
    cur_settle = settle;
    wr_cnt = 0; wr_bad = 0; rd_idx = 0; rd_bad = 0; hs_bad = 0;
    in_test = 1'b0; tap_changed = 1'b0; first_test = 1'b1; prev_pend = 1'b0;
    prev_tap = tap_out; gap = 0;
    mon_en = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !done && !cal_err, "R2 start raises busy and clears flags",
        {busy, done, cal_err}, 3'b100);
    if (extra_start) begin
      repeat (150) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R2 start while busy keeps run going", busy, 1);
    end
    while (!(done || cal_err)) @(negedge clk);
    chk(cal_err == e, "R8 error outcome", cal_err, e);
    chk(done == !e, "R9 done outcome", done, !e);
    if (!e) chk(int'(tap_out) == fin, "R9 midpoint tap", int'(tap_out), fin);
    chk(exp_q.size() == 0, "R6 R7 all expected taps tested", exp_q.size(), 0);
    chk(wr_bad == 0 && wr_cnt == PAT_LEN, "R3 pattern writes", wr_cnt, PAT_LEN);
    chk(rd_bad == 0, "R5 read order", rd_bad, 0);
    chk(hs_bad == 0, "R4 request held until ack", hs_bad, 0);
    chk(busy == 1'b0, "R2 busy low at end", busy, 0);
    mon_en = 1'b0;
    held_tap = tap_out;
    reqs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_req) reqs++;
    end
    chk(reqs == 0, "R8 no request after finish", reqs, 0);
    chk(done == !e && cal_err == e && tap_out == held_tap, "R11 result held",
        int'(tap_out), int'(held_tap));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    settle_cycles = '0;
    mask_a = '0; mask_b = '0; corrupt_at = -1; sw = 1'b0; cur_bad = 1'b0; bad = 1'b0;
    prev_tap = '0; prev_addr = '0; prev_wdata = '0; prev_we = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cal_err, "R1 flags low in reset", {busy, done, cal_err}, 0);
    chk(tap_out == '0, "R1 tap zero in reset", int'(tap_out), 0);
    chk(!mem_req, "R1 no request in reset", mem_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !mem_req, "R1 idle after reset", busy, 0);

    // window 4..11, settle 3 -> 7
    run_cal(16'h0FF0, 16'h0FF0, -1, 3, 1'b0);
    // full window, settle 0 -> 7
    run_cal(16'hFFFF, 16'hFFFF, -1, 0, 1'b0);
    // single tap 9 -> 9, restart ignored mid-run
    run_cal(16'h0200, 16'h0200, -1, 2, 1'b1);
    // window 13..15, one corrupt byte at the last address -> 14
    run_cal(16'hE000, 16'hE000, PAT_LEN - 1, 1, 1'b0);
    // window 0..1, one corrupt byte at address 0, longest settle -> 0
    run_cal(16'h0003, 16'h0003, 0, 15, 1'b0);
    // empty window: upward sweep fails at top
    run_cal(16'h0000, 16'h0000, -1, 0, 1'b0);
    // downward sweep fails through tap 0
    run_cal(16'h003C, 16'h0000, 5, 1, 1'b0);
    // a fresh run after an error succeeds
    run_cal(16'h00F0, 16'h00F0, -1, 2, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule